// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a general-purpose timer. A shared free-running counter outside the block supplies its count value, a one-cycle overflow pulse, and a flag that is high while the counter is both stopped and held in reset. The channel watches one pin and can drive that same pin. Its function comes from a 2-bit mode field and a 2-bit edge/level field. The two fields are decoded together into one of four states: the pin left to port control, input capture, unbuffered output compare/PWM, or buffered output compare/PWM.

In capture the channel synchronizes the pin, detects the selected edge, latches the counter into its 16-bit channel register and raises its flag. In compare the channel fires when the counter equals the active compare value: it toggles, clears or sets its output and raises the flag. In buffered compare, values written while the counter runs wait in a shadow register until the next counter overflow, so a PWM edge never moves within a period. Configuration is accepted only while the counter is halted.

The state register has four states: `ST_PORT`, `ST_CAPTURE`, `ST_CMP` and `ST_CMP_BUF`. Every transition is taken on an accepted configuration write (`cfg_we` while `cnt_halt`). Any state goes to `ST_PORT` when the written edge field is 00. Otherwise it goes to `ST_CAPTURE` for mode 00, to `ST_CMP` for mode 01 and to `ST_CMP_BUF` for mode 1X. With no accepted write the state holds.

Top module: `capcmp_channel`

## Requirements
- R1: After reset the channel is in port state with `pin_oe` = 0, `pin_out` = 1, `flag` = 0 and `cap_val` = 0.
- R2: When the accepted edge field is 00, `pin_oe` is 0 and `pin_out` becomes the inverse of mode bit 0 on the write edge (mode 0 gives high, 1 gives low). Mode bit 1 is ignored. `pin_out` then holds until the next accepted write.
- R3: In capture, edge code 01 captures rising edges only, 10 falling edges only and 11 both. A pin level first sampled at clock edge k is detected at edge k+2. At that edge `cap_val` takes the `cnt_val` of that cycle and `flag` sets.
- R4: In capture state `pin_oe` is 0. `pin_oe` is 1 exactly in the two compare states, that is, when the edge field is non-zero and the mode is not 00.
- R5: In compare states a cycle where `cnt_val` equals `cap_val` sets `flag` on the next clock edge. On the same edge the output toggles (edge 01), goes low (10) or goes high (11).
- R6: In unbuffered compare (mode 01) a value write (`val_we`) becomes the compare value at the next clock edge, even while the counter runs.
- R7: In buffered compare (mode 1X) a value write while the counter runs is held pending. It takes effect on the clock edge of the next `cnt_wrap` pulse, and until then the old value stays active. A write while halted takes effect at once.
- R8: `flag` stays set until a cycle with `flag_clr`. If a capture or compare event occurs in the same cycle as `flag_clr`, `flag` remains set.
- R9: Configuration writes while `cnt_halt` is 0 are ignored. The state, `pin_oe` and `pin_out` are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | 16 | Shared counter value |
| cnt_wrap | input | 1 | One-cycle counter overflow pulse |
| cnt_halt | input | 1 | Counter stopped and held in reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode field written |
| cfg_edge | input | 2 | Edge/level field written |
| val_we | input | 1 | Channel register write strobe |
| val_in | input | 16 | Channel register write data |
| flag_clr | input | 1 | Clear request for the channel flag |
| pin_in | input | 1 | Asynchronous pin level |
| pin_out | output | 1 | Channel output level |
| pin_oe | output | 1 | Channel drives the pin |
| flag | output | 1 | Channel event flag |
| cap_val | output | 16 | Active channel register (capture or compare value) |

## Verification
Several rules hold on every cycle, and the assertions check them continuously. Ignored configuration writes leave `pin_oe` unchanged. The output holds its level while the channel does not drive the pin. The flag is sticky, and an event beats a clear. A capture latches the counter value of its own cycle. The buffered compare value holds between overflows. Other behaviour can only be shown by the bench's sweeps: the decode of each of the sixteen mode/edge combinations, the two-edge synchronizer latency, the right choice of edge per code, and the exact output level after each action from each start level.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
    typedef enum logic [1:0] {
        ST_PORT    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_CMP     = 2'd2,
        ST_CMP_BUF = 2'd3
    } chan_state_e;

    localparam logic [1:0] SEL_NONE   = 2'b00;
    localparam logic [1:0] SEL_TOGGLE = 2'b01;
    localparam logic [1:0] SEL_CLEAR  = 2'b10;
    localparam logic [1:0] SEL_SET    = 2'b11;
endpackage

// File: rtl/capcmp_edge.sv
module capcmp_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          seen_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= 1'b0;
                end else if (g == 0) begin
                    chain[g] <= pin_in;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= chain[LAST];
    end

    assign rise = chain[LAST] & ~seen_q;
    assign fall = ~chain[LAST] & seen_q;
endmodule

// File: rtl/capcmp_regs.sv
module capcmp_regs #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         buffered,
    input  logic         halted,
    input  logic         wrap,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         cap_en,
    input  logic [W-1:0] cap_src,
    output logic [W-1:0] active
);
    logic [W-1:0] act_q;
    logic [W-1:0] pend_q;
    logic         pend_v;
    logic         direct_wr;
    logic         shadow_wr;

    assign direct_wr = wr_en & (~buffered | halted);
    assign shadow_wr = wr_en & buffered & ~halted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= '0;
            pend_q <= '0;
            pend_v <= 1'b0;
        end else begin
            if (cap_en) begin
                act_q <= cap_src;
            end else if (direct_wr) begin
                act_q <= wr_val;
            end else if (buffered && wrap && pend_v) begin
                act_q  <= pend_q;
            end
            if (wrap || direct_wr) begin
                pend_v <= 1'b0;
            end
            if (shadow_wr) begin
                pend_q <= wr_val;
                pend_v <= 1'b1;
            end
        end
    end

    assign active = act_q;
endmodule

// File: rtl/capcmp_ctrl.sv
module capcmp_ctrl
    import capcmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cnt_halt,
    input  logic [1:0]  cfg_mode,
    input  logic [1:0]  cfg_edge,
    input  logic        rise,
    input  logic        fall,
    input  logic        match,
    input  logic        flag_clr,
    output chan_state_e state,
    output logic        out_q,
    output logic        flag,
    output logic        pin_oe,
    output logic        cap_en,
    output logic        evt
);
    chan_state_e state_nx;
    logic [1:0]  sel_q;
    logic        cfg_ok;
    logic        cmp_hit;
    logic        out_nx;

    assign cfg_ok = cfg_we & cnt_halt;

    always_comb begin
        state_nx = state;
        if (cfg_ok) begin
            if (cfg_edge == SEL_NONE)   state_nx = ST_PORT;
            else if (cfg_mode == 2'b00) state_nx = ST_CAPTURE;
            else if (cfg_mode == 2'b01) state_nx = ST_CMP;
            else                        state_nx = ST_CMP_BUF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PORT;
            sel_q <= SEL_NONE;
        end else begin
            state <= state_nx;
            if (cfg_ok) sel_q <= cfg_edge;
        end
    end

    always_comb begin
        cap_en  = 1'b0;
        cmp_hit = 1'b0;
        pin_oe  = 1'b0;
        unique case (state)
            ST_PORT:    ;
            ST_CAPTURE: cap_en = (sel_q[0] & rise) | (sel_q[1] & fall);
            ST_CMP, ST_CMP_BUF: begin
                cmp_hit = match;
                pin_oe  = 1'b1;
            end
        endcase
        evt = cap_en | cmp_hit;
    end

    always_comb begin
        unique case (sel_q)
            SEL_TOGGLE: out_nx = ~out_q;
            SEL_CLEAR:  out_nx = 1'b0;
            SEL_SET:    out_nx = 1'b1;
            default:    out_nx = out_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b1;
            flag  <= 1'b0;
        end else begin
            if (cfg_ok && cfg_edge == SEL_NONE) out_q <= ~cfg_mode[0];
            else if (cmp_hit)                   out_q <= out_nx;
            if (evt)           flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/capcmp_channel.sv
module capcmp_channel
    import capcmp_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_val,
    input  logic         cnt_wrap,
    input  logic         cnt_halt,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_mode,
    input  logic [1:0]   cfg_edge,
    input  logic         val_we,
    input  logic [W-1:0] val_in,
    input  logic         flag_clr,
    input  logic         pin_in,
    output logic         pin_out,
    output logic         pin_oe,
    output logic         flag,
    output logic [W-1:0] cap_val
);
    chan_state_e state;
    logic        rise, fall, match, cap_en, evt;
    logic [W-1:0] active;

    capcmp_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .rise(rise), .fall(fall)
    );

    capcmp_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .buffered(state == ST_CMP_BUF), .halted(cnt_halt), .wrap(cnt_wrap),
        .wr_en(val_we), .wr_val(val_in),
        .cap_en(cap_en), .cap_src(cnt_val), .active(active)
    );

    assign match = (cnt_val == active);

    capcmp_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cnt_halt(cnt_halt),
        .cfg_mode(cfg_mode), .cfg_edge(cfg_edge),
        .rise(rise), .fall(fall), .match(match), .flag_clr(flag_clr),
        .state(state), .out_q(pin_out), .flag(flag), .pin_oe(pin_oe),
        .cap_en(cap_en), .evt(evt)
    );

    assign cap_val = active;
endmodule

// File: rtl/capcmp_channel_chk.sv
module capcmp_channel_chk
    import capcmp_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_we,
    input logic         cnt_halt,
    input logic         cnt_wrap,
    input logic         flag_clr,
    input logic [W-1:0] cnt_val,
    input logic         pin_oe,
    input logic         pin_out,
    input logic         flag,
    input logic [W-1:0] cap_val,
    input chan_state_e  state,
    input logic         evt,
    input logic         cap_en
);
    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cnt_halt) |=> $stable(pin_oe)); // R9

    AST_UNDRIVEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_oe && !(cfg_we && cnt_halt)) |=> $stable(pin_out)); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag); // R8

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag); // R8

    AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (cap_val == $past(cnt_val))); // R3

    AST_BUFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMP_BUF && !cnt_wrap && !cnt_halt && !cap_en) |=> $stable(cap_val)); // R7
endmodule

bind capcmp_channel capcmp_channel_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cnt_halt(cnt_halt),
    .cnt_wrap(cnt_wrap), .flag_clr(flag_clr), .cnt_val(cnt_val),
    .pin_oe(pin_oe), .pin_out(pin_out), .flag(flag), .cap_val(cap_val),
    .state(state), .evt(evt), .cap_en(cap_en)
);

// File: tb/capcmp_channel_test.sv
`timescale 1ns/1ps
module capcmp_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_val = 16'hFFFF;
    logic        cnt_wrap = 1'b0;
    logic        cnt_halt = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic [1:0]  cfg_edge = 2'b00;
    logic        val_we = 1'b0;
    logic [15:0] val_in = 16'h0000;
    logic        flag_clr = 1'b0;
    logic        pin_in = 1'b0;
    logic        pin_out, pin_oe, flag;
    logic [15:0] cap_val;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    capcmp_channel uut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_wrap(cnt_wrap),
        .cnt_halt(cnt_halt), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_edge(cfg_edge), .val_we(val_we), .val_in(val_in),
        .flag_clr(flag_clr), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .flag(flag), .cap_val(cap_val)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] m, input logic [1:0] e);
        cnt_halt = 1'b1;
        cfg_mode = m;
        cfg_edge = e;
        cfg_we   = 1'b1;
        tick();
        cfg_we   = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
    endtask

    task automatic write_val(input logic [15:0] v);
        val_in = v;
        val_we = 1'b1;
        tick();
        val_we = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 oe", pin_oe, 0);
        check("R1 out", pin_out, 1);
        check("R1 flag", flag, 0);
        check("R1 cap", cap_val, 0);

        // R2 / R4: sweep every mode/edge combination
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 4; e++) begin
                cfg(m[1:0], e[1:0]);
                check("R4 oe decode", pin_oe, (e != 0 && m != 0) ? 1 : 0);
                if (e == 0) check("R2 preset level", pin_out, m[0] ? 0 : 1);
            end
        end

        // R3: capture edges for codes 01, 10, 11, both directions
        for (int e = 1; e < 4; e++) begin
            for (int dir = 0; dir < 2; dir++) begin
                logic [15:0] base;
                logic [15:0] stamp;
                bit trig;
                cfg(2'b00, e[1:0]);
                check("R4 capture oe", pin_oe, 0);
                cnt_val = 16'h0100;
                pin_in  = (dir == 1) ? 1'b0 : 1'b1;
                tick(); tick(); tick(); tick();
                clear_flag();
                base  = cap_val;
                stamp = 16'h1000 + 16'(e * 16 + dir);
                cnt_val = stamp;
                pin_in  = ~pin_in;
                trig = (dir == 1) ? e[0] : e[1];
                tick(); tick();
                check("R3 latency", flag, 0);
                tick();
                check("R3 capture flag", flag, trig);
                check("R3 capture value", cap_val, trig ? stamp : base);
            end
        end
        pin_in = 1'b0;
        cnt_val = 16'hFFFF;

        // R5: compare actions for each compare mode, action and start level
        for (int m = 1; m < 4; m++) begin
            for (int a = 1; a < 4; a++) begin
                for (int lvl = 0; lvl < 2; lvl++) begin
                    logic [15:0] v;
                    logic expo;
                    v = 16'h0200 + 16'(m * 16 + a * 2 + lvl);
                    cnt_val = 16'hFFFF;
                    cfg(2'(lvl ? 0 : 1), 2'b00);
                    cfg(m[1:0], a[1:0]);
                    write_val(v);
                    clear_flag();
                    cnt_halt = 1'b0;
                    cnt_val = v - 16'd1;
                    tick();
                    check("R5 no match", flag, 0);
                    check("R5 start level", pin_out, lvl[0]);
                    cnt_val = v;
                    tick();
                    expo = (a == 1) ? ~lvl[0] : (a == 2) ? 1'b0 : 1'b1;
                    check("R5 match flag", flag, 1);
                    check("R5 action", pin_out, expo);
                    check("R4 compare oe", pin_oe, 1);
                    cnt_val = 16'hFFFF;
                end
            end
        end

        // R6: unbuffered write while running
        cfg(2'b01, 2'b01);
        write_val(16'h0100);
        clear_flag();
        cnt_halt = 1'b0;
        write_val(16'h0300);
        check("R6 new value", cap_val, 16'h0300);
        cnt_val = 16'h0300;
        tick();
        check("R6 match new", flag, 1);
        cnt_val = 16'hFFFF;

        // R7: buffered write held until overflow
        cfg(2'b01, 2'b00);
        cfg(2'b10, 2'b11);
        write_val(16'h0400);
        check("R7 halted immediate", cap_val, 16'h0400);
        clear_flag();
        cnt_halt = 1'b0;
        write_val(16'h0500);
        check("R7 pending held", cap_val, 16'h0400);
        cnt_val = 16'h0500;
        tick();
        check("R7 no early match", flag, 0);
        check("R7 out unchanged", pin_out, 0);
        cnt_val = 16'h0400;
        tick();
        check("R7 old value match", flag, 1);
        check("R7 set action", pin_out, 1);
        cnt_val = 16'hFFFF;
        clear_flag();
        cnt_wrap = 1'b1;
        tick();
        cnt_wrap = 1'b0;
        check("R7 loaded on wrap", cap_val, 16'h0500);
        cnt_val = 16'h0500;
        tick();
        check("R7 new value match", flag, 1);

        // R8: event beats clear, then clear alone
        flag_clr = 1'b1;
        tick();
        check("R8 event wins", flag, 1);
        cnt_val = 16'hFFFF;
        tick();
        flag_clr = 1'b0;
        check("R8 cleared", flag, 0);
        tick();
        check("R8 stays clear", flag, 0);

        // R9: config write while running is ignored
        cnt_halt = 1'b0;
        cfg_mode = 2'b00;
        cfg_edge = 2'b00;
        cfg_we   = 1'b1;
        tick();
        cfg_we   = 1'b0;
        check("R9 oe kept", pin_oe, 1);
        check("R9 out kept", pin_out, 1);
        cnt_val = 16'h0500;
        tick();
        check("R9 still compares", flag, 1);
        cnt_val = 16'hFFFF;
        cfg(2'b01, 2'b00);
        check("R9 accepted when halted", pin_oe, 0);
        check("R2 preset low", pin_out, 0);

        done = 1'b1;
        summary();
    end
endmodule